// File: doc/BRIEF.md
# Triple Timer Register Bank

This block is the register front end of a three-channel hardware timer. A simple memory-mapped port carries 32-bit reads and writes. A write takes effect at the clock edge where it is presented. A read returns its data, with a one-cycle valid pulse, on the cycle after it is presented. The byte offset is split into a register group and a channel. Every register type owns a group of three consecutive words, one word for each channel, so the three copies of a register sit side by side.

Each channel has its own configuration and its own counter core. The configuration covers clocking, counter control, an interval limit, three match values, an interrupt enable mask and an event-control field. The counter core holds a prescaler, a 16-bit up/down counter and the logic that detects events. Event flags collect in a per-channel interrupt status word. Reading that word clears it, and each channel drives its own interrupt line from the status masked by its enable bits.

Top module: `tri_timer_regs`

## Requirements
- R1: The word index is the byte offset shifted right by 2, so the low two offset bits are ignored. The channel is the word index modulo 3 and the group is the word index divided by 3. Groups 0 to 9 are, in order: clock setup, counter control, counter value, interval, match 1, match 2, match 3, interrupt status, interrupt enable and event control. The group base offsets are therefore 0x00, 0x0C, 0x18, 0x24, 0x30, 0x3C, 0x48, 0x54, 0x60 and 0x6C.
- R2: A read presented at a clock edge drives its data and a one-cycle valid pulse after that edge. A write never raises the valid pulse.
- R3: A clock-setup write keeps bits 5:0 and an interrupt-enable write keeps bits 5:0. An event-control write keeps bits 2:0. Interval and match writes keep bits 15:0.
- R4: A counter-control write keeps bits 5:0 but stores bit 4 as 0. Writing bit 4 as 1 returns that channel's count to 0 at the same edge.
- R5: Counter control bit 0 set stops the counter, and the reset value of counter control is 0x01. Bit 2 selects down-counting. Bit 1 selects interval mode, where the count limit is the interval register; otherwise the limit is 0xFFFF. A counter-value read returns the live count, zero-extended.
- R6: Clock setup bit 0 enables the prescaler, with N in bits 4:1. The counter then steps once every 2^(N+1) cycles, and the first step comes 2^(N+1) edges after the channel starts. With the prescaler off, the counter steps once per cycle.
- R7: An up-count at or above the limit wraps to 0. A down-count at 0 reloads the limit. Each wrap sets status bit 0 in interval mode and status bit 4 otherwise.
- R8: With counter control bit 3 set, a step whose new count equals match register k (k = 1, 2, 3) sets status bit k.
- R9: A status read returns the status word, and the word is then cleared.
- R10: An event raised in the same cycle as a clearing status read stays set and shows on the next read.
- R11: irq[c] is high while the status word and the enable mask of channel c share a set bit.
- R12: Writes to the counter-value and interrupt-status groups change nothing. Reads of offsets at or beyond group 10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-data valid pulse |
| irq | output | 3 | Per-channel interrupt line |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, 32-bit data, 16-bit counters and a 16-bit prescaler counter. The 8-bit offset reaches both the ten mapped groups and the unmapped words above them. A prescaler divide of 4 makes the stepping ratio visible in a 40-cycle run. An interval limit of 0 makes a wrap event fire on every cycle, which puts an event in the very cycle of each clearing status read.

// File: rtl/tri_tmr_pkg.sv
// Shared constants and types for the triple timer register bank.
// Assumes exactly three channels; the offset decode depends on that count.
package tri_tmr_pkg;
    localparam int NUM_CH    = 3;
    localparam int NUM_MATCH = 3;
    localparam int FLAG_W    = 6;
    localparam int NUM_GRP   = 10;

    // Counter control bit positions
    localparam int CTL_STOP  = 0;
    localparam int CTL_INTV  = 1;
    localparam int CTL_DOWN  = 2;
    localparam int CTL_MEN   = 3;
    localparam int CTL_RST   = 4;

    // Status flag positions
    localparam int FLG_WRAP_INTV = 0;
    localparam int FLG_WRAP_FULL = 4;

    typedef enum logic [3:0] {
        GRP_CLK  = 4'd0,
        GRP_CTRL = 4'd1,
        GRP_VAL  = 4'd2,
        GRP_INTV = 4'd3,
        GRP_MT1  = 4'd4,
        GRP_MT2  = 4'd5,
        GRP_MT3  = 4'd6,
        GRP_STAT = 4'd7,
        GRP_IEN  = 4'd8,
        GRP_EVC  = 4'd9,
        GRP_NONE = 4'd15
    } grp_e;
endpackage

// File: rtl/ttc_addr_dec.sv
// Offset decoder: splits a word index into register group and channel.
// Assumes WIDX_W >= 4; the group is the index divided by 3, the channel is the remainder.
module ttc_addr_dec
    import tri_tmr_pkg::*;
#(
    parameter int WIDX_W = 6
) (
    input  logic [WIDX_W-1:0] widx_i,
    output grp_e              grp_o,
    output logic [1:0]        ch_o,
    output logic              hit_o
);
    localparam logic [WIDX_W-1:0] THREE   = WIDX_W'(3);
    localparam logic [WIDX_W-1:0] GRP_LIM = WIDX_W'(NUM_GRP);

    logic [WIDX_W-1:0] quot;

    // Group quotient and channel remainder
    assign quot  = widx_i / THREE;
    assign ch_o  = 2'(widx_i % THREE);
    assign hit_o = (quot < GRP_LIM);
    assign grp_o = hit_o ? grp_e'(quot[3:0]) : GRP_NONE;
endmodule

// File: rtl/ttc_chan_core.sv
// One timer channel: prescaler, up/down counter, wrap and match event detection.
// Assumes configuration is stable register state; restart_i is a single-cycle pulse.
// Events are combinational and valid in the cycle the counter steps.
module ttc_chan_core
    import tri_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [4:0]                          clk_cfg_i,
    input  logic [3:0]                          ctl_i,
    input  logic                                restart_i,
    input  logic [CNT_W-1:0]                    intv_i,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0]     match_i,
    output logic [CNT_W-1:0]                    count_o,
    output logic [FLAG_W-1:0]                   evt_o
);
    logic [PS_W-1:0]  ps_cnt;
    logic [PS_W-1:0]  div_last;
    logic             run;
    logic             ps_on;
    logic             tick;
    logic [CNT_W-1:0] limit;
    logic             at_end;
    logic [CNT_W-1:0] nxt;

    assign run      = !ctl_i[CTL_STOP];
    assign ps_on    = clk_cfg_i[0];
    assign div_last = PS_W'((33'd2 << clk_cfg_i[4:1]) - 33'd1);
    assign tick     = run && !restart_i && (!ps_on || (ps_cnt == div_last));
    assign limit    = ctl_i[CTL_INTV] ? intv_i : {CNT_W{1'b1}};

    // Prescaler phase counter, held at zero while the channel is idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_cnt <= '0;
        else if (!run || restart_i || !ps_on || (ps_cnt == div_last))
            ps_cnt <= '0;
        else
            ps_cnt <= ps_cnt + 1'b1;
    end

    // Next count and wrap detection for both directions
    always_comb begin
        if (ctl_i[CTL_DOWN]) begin
            at_end = (count_o == '0) || (count_o > limit);
            nxt    = at_end ? limit : count_o - 1'b1;
        end else begin
            at_end = (count_o >= limit);
            nxt    = at_end ? '0 : count_o + 1'b1;
        end
    end

    // Event flags raised on a step
    always_comb begin
        evt_o = '0;
        if (tick && at_end) begin
            if (ctl_i[CTL_INTV])
                evt_o[FLG_WRAP_INTV] = 1'b1;
            else
                evt_o[FLG_WRAP_FULL] = 1'b1;
        end
        for (int k = 0; k < NUM_MATCH; k++) begin
            if (tick && ctl_i[CTL_MEN] && (nxt == match_i[k]))
                evt_o[k+1] = 1'b1;
        end
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= '0;
        else if (restart_i)
            count_o <= '0;
        else if (tick)
            count_o <= nxt;
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i[CTL_STOP] && !restart_i) |=> $stable(count_o)); // R5
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (count_o == '0)); // R4
endmodule

// File: rtl/ttc_irq_stat.sv
// Per-channel interrupt status with clear-on-read and masked IRQ outputs.
// Assumes clr_i pulses for one cycle on a status read; events raised in that cycle survive.
module ttc_irq_stat
    import tri_tmr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][FLAG_W-1:0] evt_i,
    input  logic [NUM_CH-1:0]             clr_i,
    input  logic [NUM_CH-1:0][FLAG_W-1:0] ien_i,
    output logic [NUM_CH-1:0][FLAG_W-1:0] stat_o,
    output logic [NUM_CH-1:0]             irq_o
);
    // Status accumulation: clear first, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_o <= '0;
        else
            for (int c = 0; c < NUM_CH; c++)
                stat_o[c] <= (clr_i[c] ? '0 : stat_o[c]) | evt_i[c];
    end

    // Interrupt lines from masked status
    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            irq_o[c] = |(stat_o[c] & ien_i[c]);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[g] != '0) |=> ((stat_o[g] & $past(evt_i[g])) == $past(evt_i[g]))); // R10
        AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && (evt_i[g] == '0)) |=> (stat_o[g] == '0)); // R9
    end
endmodule

// File: rtl/tri_timer_regs.sv
// Top of the triple timer register bank: decodes accesses, holds per-channel
// configuration, instantiates three counter cores and the interrupt status block.
// Assumes DATA_W >= CNT_W >= 6 and ADDR_W >= 6; reads answer one cycle later.
module tri_timer_regs
    import tri_tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [NUM_CH-1:0] irq
);
    localparam int WIDX_W = ADDR_W - 2;

    grp_e        grp;
    logic [1:0]  dec_ch;
    logic        dec_hit;
    logic        wr_acc;
    logic        rd_acc;
    logic        lsb_unused;
    logic        wdata_unused;

    logic [NUM_CH-1:0][5:0]                      clk_q;
    logic [NUM_CH-1:0][5:0]                      ctrl_q;
    logic [NUM_CH-1:0][FLAG_W-1:0]               ien_q;
    logic [NUM_CH-1:0][2:0]                      evc_q;
    logic [NUM_CH-1:0][CNT_W-1:0]                intv_q;
    logic [NUM_CH-1:0][NUM_MATCH-1:0][CNT_W-1:0] mt_q;
    logic [NUM_CH-1:0][CNT_W-1:0]                cnt;
    logic [NUM_CH-1:0][FLAG_W-1:0]               evt;
    logic [NUM_CH-1:0][FLAG_W-1:0]               stat;
    logic [NUM_CH-1:0]                           restart;
    logic [NUM_CH-1:0]                           clr;
    logic [DATA_W-1:0]                           rd_mux;

    assign lsb_unused   = ^bus_addr[1:0];
    assign wdata_unused = ^bus_wdata[DATA_W-1:CNT_W];
    assign wr_acc       = bus_sel && bus_wr;
    assign rd_acc       = bus_sel && !bus_wr;

    ttc_addr_dec #(.WIDX_W(WIDX_W)) dec_i (
        .widx_i (bus_addr[ADDR_W-1:2]),
        .grp_o  (grp),
        .ch_o   (dec_ch),
        .hit_o  (dec_hit)
    );

    // Per-channel restart pulse and status clear strobe
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            restart[c] = wr_acc && (grp == GRP_CTRL) && (dec_ch == 2'(c)) && bus_wdata[CTL_RST];
            clr[c]     = rd_acc && (grp == GRP_STAT) && (dec_ch == 2'(c));
        end
    end

    // Configuration register writes with per-group masking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= '0;
            ien_q  <= '0;
            evc_q  <= '0;
            intv_q <= '0;
            mt_q   <= '0;
            for (int c = 0; c < NUM_CH; c++)
                ctrl_q[c] <= 6'h01;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_acc && (dec_ch == 2'(c))) begin
                    case (grp)
                        GRP_CLK:  clk_q[c]    <= bus_wdata[5:0];
                        GRP_CTRL: ctrl_q[c]   <= bus_wdata[5:0] & ~6'(1 << CTL_RST);
                        GRP_INTV: intv_q[c]   <= bus_wdata[CNT_W-1:0];
                        GRP_MT1:  mt_q[c][0]  <= bus_wdata[CNT_W-1:0];
                        GRP_MT2:  mt_q[c][1]  <= bus_wdata[CNT_W-1:0];
                        GRP_MT3:  mt_q[c][2]  <= bus_wdata[CNT_W-1:0];
                        GRP_IEN:  ien_q[c]    <= bus_wdata[FLAG_W-1:0];
                        GRP_EVC:  evc_q[c]    <= bus_wdata[2:0];
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Three independent counter cores
    for (genvar g = 0; g < NUM_CH; g++) begin : g_core
        ttc_chan_core #(.CNT_W(CNT_W), .PS_W(PS_W)) core_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .clk_cfg_i (clk_q[g][4:0]),
            .ctl_i     (ctrl_q[g][3:0]),
            .restart_i (restart[g]),
            .intv_i    (intv_q[g]),
            .match_i   (mt_q[g]),
            .count_o   (cnt[g]),
            .evt_o     (evt[g])
        );
    end

    ttc_irq_stat stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .clr_i  (clr),
        .ien_i  (ien_q),
        .stat_o (stat),
        .irq_o  (irq)
    );

    // Read data selection by group and channel
    always_comb begin
        rd_mux = '0;
        case (grp)
            GRP_CLK:  rd_mux = DATA_W'(clk_q[dec_ch]);
            GRP_CTRL: rd_mux = DATA_W'(ctrl_q[dec_ch]);
            GRP_VAL:  rd_mux = DATA_W'(cnt[dec_ch]);
            GRP_INTV: rd_mux = DATA_W'(intv_q[dec_ch]);
            GRP_MT1:  rd_mux = DATA_W'(mt_q[dec_ch][0]);
            GRP_MT2:  rd_mux = DATA_W'(mt_q[dec_ch][1]);
            GRP_MT3:  rd_mux = DATA_W'(mt_q[dec_ch][2]);
            GRP_STAT: rd_mux = DATA_W'(stat[dec_ch]);
            GRP_IEN:  rd_mux = DATA_W'(ien_q[dec_ch]);
            GRP_EVC:  rd_mux = DATA_W'(evc_q[dec_ch]);
            default:  rd_mux = '0;
        endcase
    end

    // Registered read response and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_acc;
            if (rd_acc)
                bus_rdata <= dec_hit ? rd_mux : '0;
        end
    end

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid); // R2
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !bus_rvalid); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !dec_hit) |=> (bus_rdata == '0)); // R12
endmodule

// File: tb/tri_timer_regs_tb_top.sv
`timescale 1ns/1ps
module tri_timer_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    tri_timer_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    function automatic logic [7:0] ra(input int grp, input int ch);
        return 8'((grp * 3 + ch) * 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one write access, caller sits just after a falling edge
    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Driver: one read access, expected value queued for the monitor
    task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares each read response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // Reset state
        do_rd(ra(1, 0), 32'h01, "R5 reset ctrl");
        chk("R11 reset irq", 32'(irq), 32'h0);

        // R1 decode: channel by word modulo 3, low offset bits ignored
        do_wr(ra(3, 1), 32'h0000_1234);
        chk("R2 write no rvalid", 32'(bus_rvalid), 32'h0);
        do_rd(ra(3, 0), 32'h0, "R1 ch0 interval");
        do_rd(ra(3, 1), 32'h1234, "R1 ch1 interval");
        do_rd(ra(3, 1) + 8'd3, 32'h1234, "R1 low bits ignored");
        do_rd(ra(3, 2), 32'h0, "R1 ch2 interval");

        // R3 and R4 write masks on channel 2
        do_wr(ra(0, 2), 32'hFFFF_FFFF);
        do_wr(ra(1, 2), 32'hFFFF_FFFF);
        do_wr(ra(8, 2), 32'hFFFF_FFFF);
        do_wr(ra(9, 2), 32'hFFFF_FFFF);
        do_wr(ra(3, 2), 32'hFFFF_FFFF);
        do_wr(ra(6, 2), 32'hFFFF_FFFF);
        do_rd(ra(0, 2), 32'h3F, "R3 clock mask");
        do_rd(ra(1, 2), 32'h2F, "R4 ctrl mask bit4 zero");
        do_rd(ra(8, 2), 32'h3F, "R3 enable mask");
        do_rd(ra(9, 2), 32'h07, "R3 event ctrl mask");
        do_rd(ra(3, 2), 32'hFFFF, "R3 interval mask");
        do_rd(ra(6, 2), 32'hFFFF, "R3 match3 mask");

        // R12 unmapped reads and ignored status write
        do_rd(8'h78, 32'h0, "R12 unmapped 0x78");
        do_rd(8'hFC, 32'h0, "R12 unmapped 0xFC");
        do_wr(ra(7, 1), 32'h3F);
        do_rd(ra(7, 1), 32'h0, "R12 status write ignored");

        // R8 match, R11 irq, R9 clear-on-read on channel 0
        do_wr(ra(8, 0), 32'h02);
        do_wr(ra(4, 0), 32'd5);
        do_wr(ra(1, 0), 32'h11);
        do_wr(ra(1, 0), 32'h08);
        idle(9);
        do_wr(ra(1, 0), 32'h09);
        chk("R11 irq on match", 32'(irq[0]), 32'h1);
        do_rd(ra(2, 0), 32'd10, "R5 up count value");
        do_rd(ra(7, 0), 32'h02, "R8 match1 flag");
        chk("R11 irq cleared", 32'(irq[0]), 32'h0);
        do_rd(ra(7, 0), 32'h0, "R9 status cleared");

        // R12 counter value write ignored
        do_wr(ra(2, 0), 32'h0000_ABCD);
        do_rd(ra(2, 0), 32'd10, "R12 value write ignored");

        // R4 restart
        do_wr(ra(1, 0), 32'h11);
        do_rd(ra(2, 0), 32'd0, "R4 restart clears count");
        do_rd(ra(1, 0), 32'h01, "R4 restart bit not stored");

        // R6 prescaler divide by 4
        do_wr(ra(0, 0), 32'h03);
        do_wr(ra(1, 0), 32'h00);
        idle(39);
        do_wr(ra(1, 0), 32'h01);
        do_rd(ra(2, 0), 32'd10, "R6 prescaled count");
        do_wr(ra(0, 0), 32'h00);

        // R7 interval wrap counting up
        do_wr(ra(3, 0), 32'd3);
        do_wr(ra(1, 0), 32'h13);
        do_wr(ra(1, 0), 32'h02);
        idle(9);
        do_wr(ra(1, 0), 32'h03);
        do_rd(ra(2, 0), 32'd2, "R7 interval count");
        do_rd(ra(7, 0), 32'h01, "R7 interval wrap flag");

        // R7 full-range wrap counting down
        do_wr(ra(1, 0), 32'h11);
        do_wr(ra(1, 0), 32'h04);
        idle(2);
        do_wr(ra(1, 0), 32'h05);
        do_rd(ra(2, 0), 32'hFFFD, "R7 down count");
        do_rd(ra(7, 0), 32'h10, "R7 overflow flag");

        // R7 down in interval mode reloads the limit
        do_wr(ra(1, 0), 32'h13);
        do_wr(ra(1, 0), 32'h06);
        do_wr(ra(1, 0), 32'h07);
        do_rd(ra(2, 0), 32'd3, "R7 down reload");
        do_rd(ra(7, 0), 32'h01, "R7 down wrap flag");

        // R10 event in the cycle of a clearing read survives
        do_wr(ra(3, 0), 32'd0);
        do_wr(ra(8, 0), 32'h01);
        do_wr(ra(1, 0), 32'h13);
        do_wr(ra(1, 0), 32'h02);
        idle(2);
        do_rd(ra(7, 0), 32'h01, "R10 first read");
        do_rd(ra(7, 0), 32'h01, "R10 event survives clear");
        chk("R11 irq stays high", 32'(irq[0]), 32'h1);
        do_wr(ra(1, 0), 32'h03);
        do_rd(ra(7, 0), 32'h01, "R10 last event kept");
        do_rd(ra(7, 0), 32'h0, "R9 cleared after stop");

        idle(3);
        chk("R2 all reads answered", 32'(exp_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule